// File: doc/BRIEF.md
# Aligned Flash Block Writer with Fault-Log Save Timing

This controller sits between a byte-wide register write port and a flash programming engine. Flash can only be programmed a whole 8-byte block at a time. The controller collects byte writes into a block buffer and insists that each block begins on an 8-byte boundary. When the eighth byte arrives, it issues a single program command on a 64-bit output bus, together with the block base address. It then holds a busy bit for a programmable number of clock cycles, which models the long programming interval.

The same busy timer paces fault-log saves. A 2-bit mode selects what a save stores: flags and ADC readings, flags only, ADC readings only, or nothing. A save that stores both, or ADC readings only, keeps the block busy for the long interval. A flags-only save uses the short interval. A "nothing" save finishes at once. Software must poll the busy bit before it starts the next block or save. Anything that arrives while the block is busy is dropped and recorded in a sticky overrun flag.

Top module: `flashBlockWriter`

## Requirements
- R1: After reset, `status` is 3'b000, and `pgmStart` and `saveStart` are low.
- R2: The first byte of a block is accepted only when `wrAddr[2:0]` is 3'b000. That address appears on `pgmAddr` when the block launches.
- R3: If the first byte of a block has nonzero `wrAddr[2:0]`, it is discarded and no byte is counted. The align-error flag `status[0]` is set and stays set until reset.
- R4: On the clock edge that accepts the eighth byte, `pgmStart` rises for exactly one cycle. It never rises after fewer than eight accepted bytes. `pgmData[8k+7:8k]` holds the k-th accepted byte, where k runs from 0 to 7.
- R5: The busy bit `status[1]` rises on the launch edge and stays high for exactly `PGM_CYCLES` cycles.
- R6: A byte write while busy is ignored: it does not enter the buffer and is not counted. It sets the sticky overrun flag `status[2]`.
- R7: An idle save request in mode 00, 01 or 10 pulses `saveStart` for one cycle. At the same time `saveSel` = {adc, flags} is 2'b11 for mode 00, 2'b01 for mode 01 and 2'b10 for mode 10. The block is then busy for `SAVE_LONG` cycles in modes 00 and 10, and for `SAVE_SHORT` cycles in mode 01.
- R8: A save request in mode 11 produces no `saveStart`, raises no busy bit and sets no flag.
- R9: A save request of any mode while busy is ignored: there is no `saveStart` and the busy time is not extended. It sets `status[2]`.
- R10: If an idle save request in mode 00, 01 or 10 meets a byte write in the same cycle, the save wins. The byte is dropped and `status[2]` is set.
- R11: Bytes 2 to 8 of a block are placed by arrival order; their addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Byte write strobe |
| wrAddr | input | ADDR_W | Byte write address |
| wrData | input | 8 | Byte write data |
| saveReq | input | 1 | Fault-log save request |
| saveMode | input | 2 | Save content mode (00 both, 01 flags, 10 ADC, 11 none) |
| status | output | 3 | {overrun, busy, alignErr} |
| pgmStart | output | 1 | One-cycle block program command |
| pgmAddr | output | ADDR_W | Base address of the launched block |
| pgmData | output | 64 | Block contents, byte 0 in the low bits |
| saveStart | output | 1 | One-cycle save command |
| saveSel | output | 2 | Save content select {adc, flags} |

## Verification
The assertions assume that the inputs are sampled only at clock edges and that the interval parameters are at least 1. Under those assumptions the busy bit always separates two launches, and stickiness follows from reset alone. The stimulus drives every input on the falling edge, keeps each request to one cycle, and uses small interval values so that every busy window can be counted completely. Collisions are provoked on purpose: writes and saves during busy, and a save together with a write.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  typedef struct packed {
    logic       storeByte;
    logic       latchBase;
    logic [2:0] byteIdx;
  } fbwStrb_t;
endpackage

// File: rtl/fbwDatapath.sv
module fbwDatapath
  import fbw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BLK_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fbwStrb_t               strb,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  input  logic                   holdIn,
  input  logic                   launchIn,
  output logic [ADDR_W-1:0]      pgmAddr,
  output logic [BLK_BYTES*8-1:0] pgmData
);
  logic [ADDR_W-1:0] baseReg;
  logic [BLK_BYTES*8-1:0] blockBuf;

  for (genvar g = 0; g < BLK_BYTES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) blockBuf[g*8 +: 8] <= '0;
      else if (strb.storeByte && strb.byteIdx == 3'(g)) blockBuf[g*8 +: 8] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) baseReg <= '0;
    else if (strb.latchBase) baseReg <= wrAddr;
  end

  assign pgmAddr = baseReg;
  assign pgmData = blockBuf;

  // R2
  aligned_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchIn |-> pgmAddr[2:0] == 3'b000);

  // R6
  hold_buffer_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdIn |=> $stable(blockBuf));
endmodule

// File: rtl/fbwControl.sv
module fbwControl
  import fbw_pkg::*;
#(
  parameter int PGM_CYCLES = 64,
  parameter int SAVE_LONG = 80,
  parameter int SAVE_SHORT = 54,
  localparam int MAXA = (PGM_CYCLES > SAVE_LONG) ? PGM_CYCLES : SAVE_LONG,
  localparam int MAXC = (MAXA > SAVE_SHORT) ? MAXA : SAVE_SHORT,
  localparam int TW = $clog2(MAXC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [2:0] wrAddrLow,
  input  logic       saveReq,
  input  logic [1:0] saveMode,
  output fbwStrb_t   strb,
  output logic       busy,
  output logic       alignErr,
  output logic       overrun,
  output logic       pgmStart,
  output logic       saveStart,
  output logic [1:0] saveSel
);
  logic [2:0]    fillCnt;
  logic [TW-1:0] timer;
  logic          saveGo, wrTake, firstBad, wrStore, blockDone, overrunEvt;
  logic [TW-1:0] loadVal;

  always_comb begin
    saveGo     = saveReq && !busy && (saveMode != 2'b11);
    wrTake     = wrValid && !busy && !saveGo;
    firstBad   = wrTake && (fillCnt == 3'd0) && (wrAddrLow != 3'b000);
    wrStore    = wrTake && !firstBad;
    blockDone  = wrStore && (fillCnt == 3'd7);
    overrunEvt = (wrValid && !wrTake) || (saveReq && busy);
    strb.storeByte = wrStore;
    strb.latchBase = wrStore && (fillCnt == 3'd0);
    strb.byteIdx   = fillCnt;
    if (blockDone)                loadVal = TW'(PGM_CYCLES - 1);
    else if (saveMode == 2'b01)   loadVal = TW'(SAVE_SHORT - 1);
    else                          loadVal = TW'(SAVE_LONG - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt   <= '0;
      busy      <= 1'b0;
      timer     <= '0;
      alignErr  <= 1'b0;
      overrun   <= 1'b0;
      pgmStart  <= 1'b0;
      saveStart <= 1'b0;
      saveSel   <= 2'b00;
    end else begin
      if (wrStore) fillCnt <= fillCnt + 3'd1;
      if (blockDone || saveGo) begin
        busy  <= 1'b1;
        timer <= loadVal;
      end else if (busy) begin
        if (timer == '0) busy <= 1'b0;
        else timer <= timer - TW'(1);
      end
      alignErr  <= alignErr | firstBad;
      overrun   <= overrun | overrunEvt;
      pgmStart  <= blockDone;
      saveStart <= saveGo;
      saveSel   <= saveGo ? {~saveMode[0], ~saveMode[1]} : 2'b00;
    end
  end

  // R3
  sticky_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> alignErr);

  // R6
  sticky_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R4
  launch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmStart |=> !pgmStart);

  // R7
  save_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    saveStart |-> busy);

  // R8
  null_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && saveMode == 2'b11 && !busy && !wrValid) |=> (!busy && !saveStart));

  // R10
  exclusive_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pgmStart && saveStart));
endmodule

// File: rtl/flashBlockWriter.sv
module flashBlockWriter
  import fbw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PGM_CYCLES = 64,
  parameter int SAVE_LONG = 80,
  parameter int SAVE_SHORT = 54,
  localparam int BLK_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  input  logic                   saveReq,
  input  logic [1:0]             saveMode,
  output logic [2:0]             status,
  output logic                   pgmStart,
  output logic [ADDR_W-1:0]      pgmAddr,
  output logic [BLK_BYTES*8-1:0] pgmData,
  output logic                   saveStart,
  output logic [1:0]             saveSel
);
  fbwStrb_t strb;
  logic busy, alignErr, overrun;

  fbwControl #(
    .PGM_CYCLES(PGM_CYCLES), .SAVE_LONG(SAVE_LONG), .SAVE_SHORT(SAVE_SHORT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddrLow(wrAddr[2:0]),
    .saveReq(saveReq), .saveMode(saveMode), .strb(strb), .busy(busy),
    .alignErr(alignErr), .overrun(overrun), .pgmStart(pgmStart),
    .saveStart(saveStart), .saveSel(saveSel)
  );

  fbwDatapath #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .holdIn(busy), .launchIn(pgmStart), .pgmAddr(pgmAddr), .pgmData(pgmData)
  );

  assign status = {overrun, busy, alignErr};
endmodule

// File: tb/tb_flashBlockWriter.sv
module tb_flashBlockWriter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PGM = 12;
  localparam int SLONG = 9;
  localparam int SSHORT = 5;
  // {mode[1:0], startExpected, sel[1:0], busyCycles[7:0]}
  localparam logic [12:0] VEC [4] = '{
    {2'b00, 1'b1, 2'b11, 8'(SLONG)},
    {2'b01, 1'b1, 2'b01, 8'(SSHORT)},
    {2'b10, 1'b1, 2'b10, 8'(SLONG)},
    {2'b11, 1'b0, 2'b00, 8'd0}
  };

  logic clk = 1'b0, rstN = 1'b0, wrValid = 1'b0, saveReq = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] saveMode = 2'b00;
  logic [2:0] status;
  logic pgmStart, saveStart;
  logic [AW-1:0] pgmAddr;
  logic [63:0] pgmData;
  logic [1:0] saveSel;
  int vecCnt = 0, failCnt = 0;

  flashBlockWriter #(.ADDR_W(AW), .PGM_CYCLES(PGM), .SAVE_LONG(SLONG), .SAVE_SHORT(SSHORT)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .saveReq(saveReq), .saveMode(saveMode), .status(status), .pgmStart(pgmStart),
    .pgmAddr(pgmAddr), .pgmData(pgmData), .saveStart(saveStart), .saveSel(saveSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wv, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic sv, input logic [1:0] m);
    @(negedge clk);
    wrValid = wv; wrAddr = a; wrData = d; saveReq = sv; saveMode = m;
    @(negedge clk);
    wrValid = 1'b0; saveReq = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic fillBlock(input logic [AW-1:0] base, input logic [7:0] seed,
                           output logic [63:0] exp);
    exp = '0;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      logic [AW-1:0] a;
      d = seed + 8'(k * 8'h13);
      a = (k == 0) ? base : base ^ AW'(k * 37);
      exp[8*k +: 8] = d;
      drive(1'b1, a, d, 1'b0, 2'b00);
      if (k == 6) chk("R4 no launch before eighth byte", {63'd0, pgmStart}, 64'd0);
    end
  endtask

  task automatic busyLen(output int n, output logic extra);
    n = 0; extra = 1'b0;
    while (status[1]) begin
      n++;
      if (n > 1 && pgmStart) extra = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    logic [63:0] exp;
    int n;
    logic extra;
    doReset();
    chk("R1 status after reset", 64'(status), 64'd0);
    chk("R1 pgmStart after reset", {63'd0, pgmStart}, 64'd0);
    chk("R1 saveStart after reset", {63'd0, saveStart}, 64'd0);

    // Basic block at an aligned base with scattered later addresses (R2, R4, R5, R11)
    fillBlock(10'h040, 8'h21, exp);
    chk("R4 launch pulse", {63'd0, pgmStart}, 64'd1);
    chk("R2 base address", 64'(pgmAddr), 64'h040);
    chk("R11 block data by arrival order", pgmData, exp);
    busyLen(n, extra);
    chk("R5 program busy cycles", 64'(n), 64'(PGM));
    chk("R4 single-cycle launch", {63'd0, extra}, 64'd0);

    // Save mode table (R7, R8)
    for (int i = 0; i < 4; i++) begin
      logic [12:0] v;
      v = VEC[i];
      drive(1'b0, '0, 8'h00, 1'b1, v[12:11]);
      chk("R7 saveStart per mode", {63'd0, saveStart}, {63'd0, v[10]});
      if (v[10]) chk("R7 saveSel per mode", 64'(saveSel), 64'(v[9:8]));
      busyLen(n, extra);
      chk("R7 save busy cycles", 64'(n), 64'(v[7:0]));
    end
    chk("R8 no flags after null save", 64'(status), 64'd0);

    // Save while programming (R9)
    fillBlock(10'h080, 8'h30, exp);
    drive(1'b0, '0, 8'h00, 1'b1, 2'b01);
    chk("R9 no saveStart while busy", {63'd0, saveStart}, 64'd0);
    chk("R9 overrun set", {63'd0, status[2]}, 64'd1);
    busyLen(n, extra);
    chk("R9 busy not extended", 64'(n), 64'(PGM - 2));

    // Write while programming (R6)
    doReset();
    fillBlock(10'h0C0, 8'h44, exp);
    drive(1'b1, 10'h0C0, 8'hEE, 1'b0, 2'b00);
    chk("R6 overrun set", {63'd0, status[2]}, 64'd1);
    busyLen(n, extra);
    fillBlock(10'h100, 8'h55, exp);
    chk("R6 next block base", 64'(pgmAddr), 64'h100);
    chk("R6 ignored byte absent", pgmData, exp);
    busyLen(n, extra);

    // Misaligned first byte (R3)
    doReset();
    drive(1'b1, 10'h043, 8'h99, 1'b0, 2'b00);
    chk("R3 alignErr set", 64'(status), 64'b001);
    fillBlock(10'h140, 8'h70, exp);
    chk("R3 block after reject base", 64'(pgmAddr), 64'h140);
    chk("R3 rejected byte not counted", pgmData, exp);
    busyLen(n, extra);
    chk("R3 alignErr sticky", {63'd0, status[0]}, 64'd1);

    // Save colliding with a write (R10)
    doReset();
    drive(1'b1, 10'h180, 8'hAB, 1'b1, 2'b10);
    chk("R10 save wins", {63'd0, saveStart}, 64'd1);
    chk("R10 saveSel", 64'(saveSel), 64'b10);
    chk("R10 overrun set", {63'd0, status[2]}, 64'd1);
    busyLen(n, extra);
    fillBlock(10'h1C0, 8'h0F, exp);
    chk("R10 dropped byte not counted", 64'(pgmAddr), 64'h1C0);
    chk("R10 block data", pgmData, exp);
    busyLen(n, extra);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule